// File: doc/BRIEF.md
# Descriptor-Ring Invalidation Fetch Engine

This block is the hardware side of a queued invalidation interface in an I/O address-remapping unit. Software keeps a ring of 16-byte descriptors in memory. It programs the ring base and turns the queue on. It then writes command descriptors, each followed by a wait descriptor, and moves the tail index forward. While the queue is on, the engine reads descriptors at the head index one at a time and decodes them. Invalidation commands are acknowledged after a fixed latency. A wait descriptor can store a 32-bit completion value at an address given in the descriptor. The head advances by one after each descriptor completes.

The engine halts on three faults: an unknown descriptor type, a memory access that is not acknowledged in time, and a memory error response. Each fault sets its own bit in the fault register. While any fault bit is set the head stays parked on the descriptor that failed and nothing is fetched. Software clears a fault bit by writing one to it, and fetching then resumes from the parked head. Registers are reached through a simple word-indexed write port and a combinational read port. Memory is reached through a request/acknowledge port that carries 64-bit reads and 32-bit writes.

Top module: `iq_fetch_engine`

## Requirements
- R1: After reset every register reads zero (ring base, head, tail, command, enabled status, fault) and no memory request is raised.
- R2: Writing 1 to bit 0 of the command register (word 3) sets bit 0 of the status register (word 4) within two cycles and clears the head index to 0.
- R3: Once bit 0 of the command register is cleared, the status bit drops as soon as no descriptor is in flight. While the status bit is clear, no memory request is issued, even if the tail moves.
- R4: Head (word 1) and tail (word 2) read as the ring index shifted left by IDX_SHIFT. The tail is taken from write-data bits [IDX_SHIFT+IDX_W-1:IDX_SHIFT]. Indexes wrap modulo 2^IDX_W.
- R5: A fetch starts only while the queue is enabled, no fault bit is set and head differs from tail. It reads the low word at base + head*16 and then the high word at base + head*16 + 8. Base is word 0, and its low 4 bits are forced to zero.
- R6: Descriptor type is bits [3:0] of the low word. Types 1 to 4 are invalidations, acknowledged INV_LAT cycles after decode. Type 5 is a wait. The head advances by exactly one per completed descriptor.
- R7: A wait descriptor with bit 5 of its low word set writes bits [63:32] of its low word to the address in its high word. With bit 5 clear it writes nothing.
- R8: Types 0 and 6 to 15 set fault bit 0 (word 5). The head stays on the offending descriptor and nothing is fetched until the bit is cleared.
- R9: A memory request not acknowledged within TIMEOUT_CYC cycles sets fault bit 2. The head stays parked, the pending wait writes no status, and fetching stops until the bit is cleared.
- R10: A memory acknowledge carrying an error response sets fault bit 1, and fetching halts with the head parked.
- R11: Fault bits clear only when a 1 is written to them; writing 0 to a bit leaves it unchanged. Once all fault bits are clear, fetching resumes from the parked head.
- R12: Register words 0 to 5 are base, head, tail, command, status and fault. Words 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a 32-bit status write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Status data to write |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 64 | Read data, valid with mem_ack |

## Verification
The bench builds the engine with a 16-entry ring (IDX_W=4), an invalidation latency of 3 cycles and a 40-cycle memory timeout. The small ring makes the index wrap happen several times during the random rounds. The short timeout lets a stalled memory trigger the timeout halt within a few dozen cycles. Memory latency is varied at random between zero and two cycles, so descriptor fetches and status writes are checked with and without back-pressure.

// File: rtl/iq_fetch_engine.sv
module iq_fetch_engine #(
  parameter int IDX_W       = 8,
  parameter int IDX_SHIFT   = 4,
  parameter int ADDR_W      = 32,
  parameter int INV_LAT     = 8,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [63:0]       mem_rdata
);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int LAT_W = $clog2(INV_LAT + 1);
  localparam logic [3:0] T_FIRST = 4'd1;
  localparam logic [3:0] T_WAIT  = 4'd5;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_EXEC, S_STAT} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base_q, hi_q;
  logic [IDX_W-1:0]  head_q, tail_q;
  logic              cmd_en_q, enabled_q;
  logic              f_iqe, f_ice, f_ite;
  logic [63:0]       lo_q;
  logic [TO_W-1:0]   tmo_q;
  logic [LAT_W-1:0]  lat_q;

  wire        halted   = f_iqe | f_ice | f_ite;
  wire        fault_wr = reg_we && reg_addr == 3'd5;
  wire        busy_mem = st == S_LO || st == S_HI || st == S_STAT;
  wire        tmo_hit  = busy_mem && !mem_ack && tmo_q == TO_W'(TIMEOUT_CYC - 1);
  wire [3:0]  dtype    = lo_q[3:0];
  wire        type_ok  = dtype >= T_FIRST && dtype <= T_WAIT;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata, mem_rdata[63:32], lo_q[31:6], lo_q[4]};

  assign mem_req   = busy_mem;
  assign mem_we    = st == S_STAT;
  assign mem_wdata = lo_q[63:32];
  assign mem_addr  = (st == S_STAT) ? hi_q
                   : base_q + (ADDR_W'(head_q) << IDX_SHIFT)
                     + ((st == S_HI) ? ADDR_W'(8) : ADDR_W'(0));

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(base_q);
      3'd1:    reg_rdata = 32'(head_q) << IDX_SHIFT;
      3'd2:    reg_rdata = 32'(tail_q) << IDX_SHIFT;
      3'd3:    reg_rdata = {31'b0, cmd_en_q};
      3'd4:    reg_rdata = {31'b0, enabled_q};
      3'd5:    reg_rdata = {29'b0, f_ite, f_ice, f_iqe};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base_q    <= '0;
      hi_q      <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      cmd_en_q  <= 1'b0;
      enabled_q <= 1'b0;
      f_iqe     <= 1'b0;
      f_ice     <= 1'b0;
      f_ite     <= 1'b0;
      lo_q      <= '0;
      tmo_q     <= '0;
      lat_q     <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: base_q   <= ADDR_W'(reg_wdata) & ~ADDR_W'(15);
          3'd2: tail_q   <= reg_wdata[IDX_SHIFT +: IDX_W];
          3'd3: cmd_en_q <= reg_wdata[0];
          default: ;
        endcase
      end
      if (fault_wr) begin
        if (reg_wdata[0]) f_iqe <= 1'b0;
        if (reg_wdata[1]) f_ice <= 1'b0;
        if (reg_wdata[2]) f_ite <= 1'b0;
      end

      if (cmd_en_q && !enabled_q) begin
        enabled_q <= 1'b1;
        head_q    <= '0;
      end else if (!cmd_en_q && enabled_q && st == S_IDLE) begin
        enabled_q <= 1'b0;
      end

      case (st)
        S_IDLE: begin
          tmo_q <= '0;
          if (enabled_q && cmd_en_q && !halted && head_q != tail_q) st <= S_LO;
        end
        S_LO: begin
          if (mem_ack) begin
            tmo_q <= '0;
            if (mem_err) begin
              f_ice <= 1'b1;
              st    <= S_IDLE;
            end else begin
              lo_q <= mem_rdata;
              st   <= S_HI;
            end
          end else if (tmo_hit) begin
            f_ite <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        S_HI: begin
          if (mem_ack) begin
            tmo_q <= '0;
            if (mem_err) begin
              f_ice <= 1'b1;
              st    <= S_IDLE;
            end else if (!type_ok) begin
              f_iqe <= 1'b1;
              st    <= S_IDLE;
            end else if (dtype == T_WAIT) begin
              if (lo_q[5]) begin
                hi_q <= mem_rdata[ADDR_W-1:0];
                st   <= S_STAT;
              end else begin
                head_q <= head_q + 1'b1;
                st     <= S_IDLE;
              end
            end else begin
              lat_q <= '0;
              st    <= S_EXEC;
            end
          end else if (tmo_hit) begin
            f_ite <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        S_EXEC: begin
          if (lat_q == LAT_W'(INV_LAT - 1)) begin
            head_q <= head_q + 1'b1;
            st     <= S_IDLE;
          end else begin
            lat_q <= lat_q + 1'b1;
          end
        end
        S_STAT: begin
          if (mem_ack) begin
            tmo_q <= '0;
            st    <= S_IDLE;
            if (mem_err) f_ice <= 1'b1;
            else         head_q <= head_q + 1'b1;
          end else if (tmo_hit) begin
            f_ite <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  head_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && enabled_q) |=> $stable(head_q));

  // R3
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled_q |-> !mem_req);

  // R6
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(head_q) && $past(enabled_q)) |-> head_q == IDX_W'($past(head_q) + 1'b1));

  // R11
  iqe_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_iqe) |-> $past(fault_wr && reg_wdata[0]));

  // R11
  ite_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_ite) |-> $past(fault_wr && reg_wdata[2]));

  // R5
  fetch_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LO && $past(st) == S_IDLE) |-> $past(enabled_q && !halted && head_q != tail_q));
endmodule

// File: tb/iq_fetch_engine_bench.sv
module iq_fetch_engine_bench;
  localparam int IDX_W = 4;
  localparam int RING  = 1 << IDX_W;
  localparam int TMO   = 40;
  localparam logic [31:0] BASE = 32'h1000;
  localparam logic [31:0] STAT = 32'h1800;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 0, mem_err = 0;
  logic [63:0] mem_rdata = 0;

  iq_fetch_engine #(.IDX_W(IDX_W), .IDX_SHIFT(4), .ADDR_W(32), .INV_LAT(3), .TIMEOUT_CYC(TMO))
    u_iq_fetch_engine (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
                       .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_err, .mem_rdata);

  always #2.5 clk = ~clk;

  logic [63:0] mem [0:1023];
  int  errs = 0, checks = 0;
  int  wcnt = 0, lat = 0, req_cnt = 0;
  bit  stall = 0, err_next = 0;
  logic [31:0] last_rd = 0;
  int  sw_tail = 0, slot = 0;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0; mem_err = 0; wcnt = 0;
    end else if (!mem_req) begin
      wcnt = 0;
    end else if (!stall) begin
      if (wcnt >= lat) begin
        mem_ack = 1;
        if (err_next) begin mem_err = 1; err_next = 0; end
        if (mem_we) begin
          if (!mem_err) mem[mem_addr[12:3]][31:0] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[12:3]];
          last_rd = mem_addr;
        end
        req_cnt++;
        wcnt = 0;
        lat = $urandom_range(0, 2);
      end else wcnt++;
    end
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  function automatic logic [63:0] wait_lo(input logic [31:0] data, input bit flag);
    return {data, 26'b0, flag, 1'b0, 4'd5};
  endfunction

  function automatic int ring_word(input int idx);
    return (BASE >> 3) + (idx % RING) * 2;
  endfunction

  function automatic int stat_word(input int k);
    return (STAT >> 3) + k;
  endfunction

  // places cmd+wait at the tail, returns the status slot; does not move the tail register
  task automatic put_pair(input logic [3:0] ty, input logic [31:0] data, input bit flag, output int k);
    k = slot; slot = (slot + 1) % 64;
    mem[stat_word(k)] = {32'h0, 32'hDEAD0000 | k};
    mem[ring_word(sw_tail)]     = {60'h0, ty};
    mem[ring_word(sw_tail) + 1] = 64'h0;
    mem[ring_word(sw_tail + 1)]     = wait_lo(data, flag);
    mem[ring_word(sw_tail + 1) + 1] = {32'h0, STAT + 32'(k * 8)};
    sw_tail = (sw_tail + 2) % RING;
  endtask

  task automatic push_tail();
    wr(3'd2, 32'(sw_tail) << 4);
  endtask

  task automatic drain();
    logic [31:0] h, f;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, h); rd(3'd5, f);
      if (h == (32'(sw_tail) << 4) || f != 0) break;
    end
  endtask

  initial begin
    int unsigned seed0;
    logic [31:0] v, f;
    int k, cmd_idx, rc0;
    seed0 = $urandom(32'h5EED);
    for (int i = 0; i < 1024; i++) mem[i] = 64'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reg reset", v, 0);
    end
    chk("R1 no request", mem_req, 0);

    // R12 map and base masking
    wr(3'd0, BASE | 32'h7);
    rd(3'd0, v); chk("R12 base low bits", v, BASE);
    rd(3'd6, v); chk("R12 word 6", v, 0);
    rd(3'd7, v); chk("R12 word 7", v, 0);

    // R2 enable handshake
    wr(3'd2, 0); wr(3'd3, 1);
    @(negedge clk); @(negedge clk);
    rd(3'd4, v); chk("R2 enabled status", v, 1);
    rd(3'd1, v); chk("R2 head zero", v, 0);

    // R4 R6 R7 random rounds, wrap the 16-entry ring several times
    for (int r = 0; r < 14; r++) begin
      int n = $urandom_range(1, 3);
      int ks[3]; logic [31:0] ds[3]; bit fl[3];
      for (int p = 0; p < n; p++) begin
        ds[p] = $urandom; fl[p] = ($urandom_range(0, 3) != 0);
        put_pair(4'($urandom_range(1, 4)), ds[p], fl[p], ks[p]);
      end
      push_tail();
      drain();
      rd(3'd1, v); chk("R4 head equals tail after drain", v, 32'(sw_tail) << 4);
      rd(3'd5, f); chk("R6 no fault on valid types", f, 0);
      for (int p = 0; p < n; p++)
        chk(fl[p] ? "R7 status written" : "R7 flag clear no write",
            mem[stat_word(ks[p])][31:0], fl[p] ? ds[p] : (32'hDEAD0000 | ks[p]));
    end
    chk("R5 last fetch address", last_rd, BASE + 32'(((sw_tail + RING - 1) % RING) * 16 + 8));

    // R8 invalid type parks head
    cmd_idx = sw_tail;
    put_pair(4'hC, 32'hA5A5_0001, 1, k);
    push_tail();
    drain();
    rd(3'd5, f); chk("R8 invalid fault bit", f, 1);
    rd(3'd1, v); chk("R8 head parked", v, 32'(cmd_idx) << 4);
    rc0 = req_cnt;
    put_pair(4'd1, 32'hA5A5_0002, 1, k);
    k = (k + 63) % 64;
    push_tail();
    repeat (20) @(negedge clk);
    chk("R8 no fetch while halted", req_cnt, rc0);
    rd(3'd1, v); chk("R8 head still parked", v, 32'(cmd_idx) << 4);
    chk("R8 wait not written", mem[stat_word(k)][31:0], 32'hDEAD0000 | k);
    wr(3'd5, 32'h6);
    rd(3'd5, f); chk("R11 zero bit leaves fault", f, 1);
    mem[ring_word(cmd_idx)] = {60'h0, 4'd2};
    wr(3'd5, 32'h1);
    drain();
    rd(3'd5, f); chk("R11 resumed no fault", f, 0);
    rd(3'd1, v); chk("R11 resumed drains", v, 32'(sw_tail) << 4);
    chk("R11 status after resume", mem[stat_word(k)][31:0], 32'hA5A5_0001);
    chk("R11 second pair status", mem[stat_word((k + 1) % 64)][31:0], 32'hA5A5_0002);

    // R9 timeout
    stall = 1;
    cmd_idx = sw_tail;
    put_pair(4'd3, 32'hBEEF_0009, 1, k);
    push_tail();
    repeat (TMO + 20) @(negedge clk);
    rd(3'd5, f); chk("R9 timeout fault bit", f, 4);
    rd(3'd1, v); chk("R9 head parked", v, 32'(cmd_idx) << 4);
    chk("R9 pending wait not written", mem[stat_word(k)][31:0], 32'hDEAD0000 | k);
    stall = 0;
    repeat (5) @(negedge clk);
    chk("R9 still silent until cleared", mem[stat_word(k)][31:0], 32'hDEAD0000 | k);
    wr(3'd5, 32'h4);
    drain();
    chk("R9 status after clear", mem[stat_word(k)][31:0], 32'hBEEF_0009);

    // R10 memory error
    err_next = 1;
    cmd_idx = sw_tail;
    put_pair(4'd4, 32'hC0DE_0010, 1, k);
    push_tail();
    drain();
    rd(3'd5, f); chk("R10 error fault bit", f, 2);
    rd(3'd1, v); chk("R10 head parked", v, 32'(cmd_idx) << 4);
    wr(3'd5, 32'h2);
    drain();
    rd(3'd5, f); chk("R11 error cleared", f, 0);
    chk("R10 status after clear", mem[stat_word(k)][31:0], 32'hC0DE_0010);

    // R3 disable
    wr(3'd3, 0);
    @(negedge clk); @(negedge clk);
    rd(3'd4, v); chk("R3 status cleared", v, 0);
    rd(3'd1, v);
    rc0 = req_cnt;
    put_pair(4'd1, 32'h1111_0000, 1, k);
    push_tail();
    repeat (30) @(negedge clk);
    chk("R3 no requests while off", req_cnt, rc0);
    rd(3'd1, f); chk("R3 head unmoved while off", f, v);

    // R2 re-enable resets head
    sw_tail = 0;
    wr(3'd2, 0); wr(3'd3, 1);
    @(negedge clk); @(negedge clk);
    rd(3'd4, v); chk("R2 re-enabled", v, 1);
    rd(3'd1, v); chk("R2 head back to zero", v, 0);
    put_pair(4'd2, 32'h2222_0000, 1, k);
    push_tail();
    drain();
    chk("R2 works after re-enable", mem[stat_word(k)][31:0], 32'h2222_0000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule